// File: doc/BRIEF.md
# Partial-Word Store-Bytes Write Unit

This unit converts a "store bytes" request into exactly one aligned 32-bit big-endian memory write. The write carries per-byte enables. A request carries a byte address, a register value and a mode bit.

- In **begin** mode, the unit stores the low-order part of the register. The bytes run from the addressed byte to the end of the word.
- In **end** mode, the unit stores the high-order part of the register. The bytes fill the part of the word that lies below the addressed byte.

The register value always keeps its own byte lanes. Only the enable mask changes. A three-byte store is therefore always one masked word write, so it appears atomic to memory.

An end-mode request at offset zero enables no byte, but it still produces an output beat. That beat raises a probe strobe, so the memory side can check write permission for the address.

Both sides use valid/ready handshakes:
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The resulting write is presented, registered, on the following cycle.
- While `wr_valid` is high and `wr_ready` is low, the write beat holds every output field steady.
- `req_ready` stays low while a beat is held. This back-pressures the requester.
- When `wr_ready` is high, a new request can be accepted in the same cycle that the held beat leaves.

Top module: `sbw_store_bytes`

## Requirements
- R1: `wr_addr` equals `req_addr` with its two low bits cleared. `wr_data` equals `req_data` unchanged. Byte offset k of the word is `wr_data[31-8k -: 8]` and is enabled by `wr_be[3-k]` (offset 0 is the most significant byte).
- R2: Begin mode (`req_mode`=0) enables offsets from the address offset through 3. The resulting `wr_be` is 1111, 0111, 0011 and 0001 for offsets 0, 1, 2 and 3.
- R3: End mode (`req_mode`=1) enables offsets below the address offset. The resulting `wr_be` is 1000, 1100 and 1110 for offsets 1, 2 and 3.
- R4: End mode at offset 0 gives `wr_be`=0000 with `wr_probe`=1. `wr_probe` is 0 for every other request.
- R5: Each accepted request yields exactly one output beat. This includes the three-byte cases, which are never split into several writes.
- R6: `wr_valid` rises in the cycle after a request is accepted.
- R7: While `wr_valid`=1 and `wr_ready`=0, all `wr_*` outputs stay stable and `req_ready` is 0. `req_ready` is 1 whenever `wr_valid` is 0 or `wr_ready` is 1.
- R8: During and right after reset, `wr_valid`=0 and `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_mode | input | 1 | 0 = begin, 1 = end |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | DATA_W | Register value |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory takes the beat |
| wr_addr | output | ADDR_W | Word-aligned address |
| wr_data | output | DATA_W | Write data on its lanes |
| wr_be | output | DATA_W/8 | Byte enables, bit 3 = offset 0 |
| wr_probe | output | 1 | Write-permission probe, empty store |

## Verification
The hardest situation to reach is a held beat being released in the same edge that takes a new request. Reaching it requires `wr_ready` to be low for some cycles while a second request waits, and then to rise. The bench stalls the output with a three-byte write pending. It presents an end-mode offset-zero probe request while the output is stalled. It then releases the output and checks three things: the first beat stayed intact, the second beat followed on the next cycle, and the three-byte write left in a single beat.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic {
    SB_BEGIN = 1'b0,
    SB_END   = 1'b1
  } sb_mode_e;
endpackage

// File: rtl/sbw_lane_decode.sv
module sbw_lane_decode
  import sbw_pkg::*;
#(
  parameter int NBYTES = 4,
  localparam int OFS_W = $clog2(NBYTES)
) (
  input  sb_mode_e           mode,
  input  logic [OFS_W-1:0]   ofs,
  output logic [NBYTES-1:0]  be,
  output logic               probe
);
  // Lane k is byte offset k in the word; its enable bit is NBYTES-1-k.
  for (genvar k = 0; k < NBYTES; k++) begin : g_lane
    logic at_or_above;
    assign at_or_above = (OFS_W'(k) >= ofs);
    assign be[NBYTES-1-k] = (mode == SB_BEGIN) ? at_or_above : !at_or_above;
  end

  assign probe = (mode == SB_END) && (ofs == '0);
endmodule

// File: rtl/sbw_out_stage.sv
module sbw_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/sbw_store_bytes.sv
module sbw_store_bytes
  import sbw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFS_W  = $clog2(NBYTES),
  localparam int PAY_W  = ADDR_W + DATA_W + NBYTES + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [NBYTES-1:0] wr_be,
  output logic              wr_probe
);
  logic [NBYTES-1:0] dec_be;
  logic              dec_probe;
  logic [ADDR_W-1:0] word_addr;
  logic [PAY_W-1:0]  pay_in, pay_out;

  sbw_lane_decode #(.NBYTES(NBYTES)) u_dec (
    .mode  (sb_mode_e'(req_mode)),
    .ofs   (req_addr[OFS_W-1:0]),
    .be    (dec_be),
    .probe (dec_probe)
  );

  assign word_addr = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
  assign pay_in    = {word_addr, req_data, dec_be, dec_probe};

  sbw_out_stage #(.W(PAY_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   (pay_in),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .out_data  (pay_out)
  );

  assign {wr_addr, wr_data, wr_be, wr_probe} = pay_out;
endmodule

// File: rtl/sbw_store_bytes_chk.sv
module sbw_store_bytes_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NBYTES = DATA_W / 8,
  localparam int OFS_W  = $clog2(NBYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [NBYTES-1:0] wr_be,
  input logic              wr_probe
);
  assert_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_addr[OFS_W-1:0] == '0));

  assert_probe_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_probe) |-> (wr_be == '0));

  assert_nonprobe_writes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_probe) |-> (wr_be != '0));

  assert_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> wr_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)
                                 && $stable(wr_be) && $stable(wr_probe)));

  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_valid || wr_ready) |-> req_ready);

  assert_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |-> !req_ready);
endmodule

bind sbw_store_bytes sbw_store_bytes_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .wr_be     (wr_be),
  .wr_probe  (wr_probe)
);

// File: tb/sbw_store_bytes_tb.sv
module sbw_store_bytes_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_mode = 1'b0;
  logic [31:0] req_addr = '0, req_data = '0;
  logic        req_ready, wr_valid, wr_probe;
  logic        wr_ready = 1'b1;
  logic [31:0] wr_addr, wr_data;
  logic [3:0]  wr_be;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  sbw_store_bytes u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_probe(wr_probe)
  );

  // {mode, offset[1:0], expected be[3:0], expected probe}
  localparam logic [7:0] VEC [8] = '{
    {1'b0, 2'd0, 4'b1111, 1'b0}, {1'b0, 2'd1, 4'b0111, 1'b0},
    {1'b0, 2'd2, 4'b0011, 1'b0}, {1'b0, 2'd3, 4'b0001, 1'b0},
    {1'b1, 2'd0, 4'b0000, 1'b1}, {1'b1, 2'd1, 4'b1000, 1'b0},
    {1'b1, 2'd2, 4'b1100, 1'b0}, {1'b1, 2'd3, 4'b1110, 1'b0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_beat(input string tag, input logic [31:0] a, input logic [31:0] d,
                            input logic [3:0] be, input logic pr);
    chk({tag, " R6 valid"}, 64'(wr_valid), 64'(1));
    chk({tag, " R1 addr"}, 64'(wr_addr), 64'({a[31:2], 2'b00}));
    chk({tag, " R1 data"}, 64'(wr_data), 64'(d));
    chk({tag, " R2/R3 be"}, 64'(wr_be), 64'(be));
    chk({tag, " R4 probe"}, 64'(wr_probe), 64'(pr));
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset valid", 64'(wr_valid), 64'(0));
    chk("R8 reset ready", 64'(req_ready), 64'(1));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 post-reset valid", 64'(wr_valid), 64'(0));

    for (int i = 0; i < 8; i++) begin
      logic [31:0] a, d;
      a = 32'h1000_0000 + 32'(i * 16) + 32'(VEC[i][6:5]);
      d = 32'hA1B2_C3D0 ^ 32'(i * 32'h0101_0101);
      req_valid = 1'b1; req_mode = VEC[i][7]; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
      check_beat($sformatf("vec%0d", i), a, d, VEC[i][4:1], VEC[i][0]);
    end
    @(negedge clk);
    chk("R5 single beat after burst", 64'(wr_valid), 64'(0));

    // Three-byte begin write under stall, then end-mode offset-0 probe waiting behind it.
    wr_ready = 1'b0;
    req_valid = 1'b1; req_mode = 1'b0; req_addr = 32'h2000_0041; req_data = 32'h1122_3344;
    @(negedge clk);
    req_mode = 1'b1; req_addr = 32'h3000_0080; req_data = 32'h5566_7788;
    check_beat("stall first", 32'h2000_0041, 32'h1122_3344, 4'b0111, 1'b0);
    chk("R7 ready low while stalled", 64'(req_ready), 64'(0));
    repeat (2) @(negedge clk);
    check_beat("R7 held", 32'h2000_0041, 32'h1122_3344, 4'b0111, 1'b0);
    wr_ready = 1'b1;
    #0.1;
    chk("R7 ready with wr_ready", 64'(req_ready), 64'(1));
    @(negedge clk);
    req_valid = 1'b0;
    check_beat("R4 probe after release", 32'h3000_0080, 32'h5566_7788, 4'b0000, 1'b1);
    @(negedge clk);
    chk("R5 no extra beat", 64'(wr_valid), 64'(0));

    // End-mode three-byte write leaves as a single beat.
    req_valid = 1'b1; req_mode = 1'b1; req_addr = 32'h4000_0007; req_data = 32'hDEAD_BEEF;
    @(negedge clk);
    req_valid = 1'b0;
    check_beat("R3 end three-byte", 32'h4000_0007, 32'hDEAD_BEEF, 4'b1110, 1'b0);
    @(negedge clk);
    chk("R5 three-byte one beat", 64'(wr_valid), 64'(0));

    // Reset while a beat is held.
    wr_ready = 1'b0; req_valid = 1'b1; req_mode = 1'b0; req_addr = 32'h10;
    @(negedge clk);
    req_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk("R8 reset clears held beat", 64'(wr_valid), 64'(0));
    chk("R8 reset ready", 64'(req_ready), 64'(1));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule